// File: doc/BRIEF.md
# Programmable Two-Layer Perceptron Evaluator

This block computes one forward pass of a single-hidden-layer perceptron. A host keeps a small set of topology slots, each holding an input count, a hidden count, an output count and two weight base addresses. A run names one slot, streams in the input vector, and receives the output values as a stream. All weights come from an external synchronous memory with one cycle of read latency.

The hidden layer and the output layer are separate engines. Each engine has `LANES` multipliers, two by default, so four in all. Each engine reads its own weight port, with one weight address and one weight byte per lane. The lanes work on neighbouring neurons at the same time and share one operand. The hidden engine writes clipped hidden values into one half of a two-bank buffer. The output engine reads the other half. A new sample can therefore enter the hidden engine while the output engine is still working on the previous one.

The input and output streams use valid/ready. A beat transfers on a rising edge when both valid and ready are high. While `out_valid` is high and `out_ready` is low, the output stream holds `out_data` and `out_last` unchanged. `in_ready` is high only while the block is collecting inputs, so the sender can stall for any number of cycles. The control pins `start`, `start_ready` and `done`, and the configuration write pins, are plain levels and pulses.

Top module: `mlp_eval`

## Requirements
- R1: A configuration write (`cfg_we` high on a clock edge) stores into slot `cfg_idx` the input, hidden and output counts, each encoded as the count minus one, plus the two weight base addresses. After reset every slot holds counts of 1 and bases of 0.
- R2: A pulse on `start` is taken only on an edge where `start_ready` is high. On that edge the block copies slot `start_cfg`. Any later write to that slot has no effect on the run already started.
- R3: After a start has been taken, `in_ready` stays high until exactly N inputs have been accepted, where N is the input count. It is low at every other time. Input i is the i-th beat accepted, counting from 0.
- R4: Hidden value j equals the sum over i of x[i]·W[B1 + j·N + i], clipped to the signed range −128..127. W is the memory read as signed bytes, B1 is the first base, and addresses wrap at 20 bits.
- R5: Output k equals the sum over j of h[j]·W[B2 + k·H + j], where H is the hidden count. It is delivered as a 24-bit signed value. Outputs leave in order k = 0, 1, …, and `out_last` is high on the final beat of a sample.
- R6: Weight data for an address driven in one cycle is taken from the port in the next cycle. Lane L of an engine (bits L·20 upward on the address port, L·8 upward on the data port) serves neuron row+L.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values on the next edge.
- R8: `start_ready` returns high once a sample's hidden values are complete, even while the output engine is stalled. When both hidden banks are full, the hidden engine waits and `start_ready` stays low.
- R9: `done` is high for exactly one cycle, in the cycle after the beat that carries `out_last`.
- R10: After reset, `start_ready` is high, and `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a topology slot |
| cfg_idx | input | $clog2(NCFG) | Slot to write |
| cfg_ni_m1 | input | $clog2(NI_MAX) | Input count minus one |
| cfg_nh_m1 | input | $clog2(NH_MAX) | Hidden count minus one |
| cfg_no_m1 | input | $clog2(NO_MAX) | Output count minus one |
| cfg_base1 | input | 20 | Hidden-layer weight base address |
| cfg_base2 | input | 20 | Output-layer weight base address |
| start | input | 1 | Begin a sample |
| start_cfg | input | $clog2(NCFG) | Slot used by the sample |
| start_ready | output | 1 | A start would be taken |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 8 | Signed input value |
| w1_addr | output | LANES·20 | Hidden-layer weight addresses, one per lane |
| w1_data | input | LANES·8 | Hidden-layer weight bytes, one cycle after the address |
| w2_addr | output | LANES·20 | Output-layer weight addresses, one per lane |
| w2_data | input | LANES·8 | Output-layer weight bytes, one cycle after the address |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | 24 | Signed output value |
| out_last | output | 1 | Final output of the sample |
| done | output | 1 | One-cycle pulse after the final output beat |

## Verification
The bench exercises odd neuron counts, where the upper lane is idle on the last group. If that lane is not masked, it writes past the hidden row or emits an extra output beat. Large inputs push hidden sums past the clip limits, so a wrong or missing saturation shows up as wrong outputs. A configuration whose weight rows cross the top of the 20-bit space catches a wrong address step or missing wrap. With the output held back, the bench confirms that a second sample still enters and that a third one stalls. Without the bank handshake, a third sample would overwrite hidden values that are still being read. A slot is rewritten in the middle of a run to show that the copied topology is the one used. Random back-pressure detects data that changes while stalled, a `done` pulse in the wrong cycle, and misaligned weight and operand pairs.

// File: rtl/mlpe_pkg.sv
package mlpe_pkg;
  localparam int DAT_W = 8;
  localparam int ACC_W = 24;
  localparam int WA_W  = 20;

  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (DAT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  // Saturating clip of an accumulator to the operand width.
  function automatic logic signed [DAT_W-1:0] sat_clip(input logic signed [ACC_W-1:0] a);
    if (a > SAT_HI) return SAT_HI[DAT_W-1:0];
    else if (a < SAT_LO) return SAT_LO[DAT_W-1:0];
    else return a[DAT_W-1:0];
  endfunction
endpackage

// File: rtl/mlpe_dot_engine.sv
module mlpe_dot_engine
  import mlpe_pkg::*;
#(
  parameter int LANES = 2,
  parameter int ROW_W = 7,
  parameter int COL_W = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             go,
  input  logic [ROW_W-1:0]                 rows_m1,
  input  logic [COL_W-1:0]                 cols_m1,
  input  logic [WA_W-1:0]                  base,
  output logic [LANES-1:0][WA_W-1:0]       w_addr,
  input  logic [LANES-1:0][DAT_W-1:0]      w_data,
  output logic [COL_W-1:0]                 op_idx,
  input  logic signed [DAT_W-1:0]          op_val,
  output logic                             res_valid,
  input  logic                             res_ready,
  output logic [LANES-1:0][ACC_W-1:0]      res_acc,
  output logic [ROW_W:0]                   res_row,
  output logic [LANES-1:0]                 res_mask,
  output logic                             fin
);
  localparam int XW = ROW_W + 2;

  typedef enum logic [1:0] {E_IDLE, E_ISSUE, E_DRAIN, E_HOLD} est_t;
  est_t st;

  logic [ROW_W:0]              row_q;
  logic [ROW_W-1:0]            rows_q;
  logic [COL_W-1:0]            col_q, cols_q, opi_q;
  logic [WA_W-1:0]             rb_q, ncols;
  logic                        pend;
  logic [LANES-1:0][ACC_W-1:0] acc;
  logic signed [2*DAT_W-1:0]   prod [LANES];
  logic                        last_grp;

  assign ncols    = WA_W'(cols_q) + WA_W'(1);
  assign last_grp = (XW'(row_q) + XW'(LANES)) > XW'(rows_q);

  // Lane k serves neuron row_q + k and shares the operand column.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign w_addr[k]   = rb_q + WA_W'(k) * ncols + WA_W'(col_q);
    assign res_mask[k] = (XW'(row_q) + XW'(k)) <= XW'(rows_q);
    assign res_acc[k]  = acc[k];
    always_comb prod[k] = $signed(w_data[k]) * op_val;
  end

  assign res_valid = (st == E_HOLD);
  assign res_row   = row_q;
  assign op_idx    = opi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; row_q <= '0; rows_q <= '0; col_q <= '0; cols_q <= '0;
      opi_q <= '0; rb_q <= '0; pend <= 1'b0; acc <= '0; fin <= 1'b0;
    end else begin
      fin  <= 1'b0;
      pend <= 1'b0;
      case (st)
        E_IDLE: if (go) begin
          rows_q <= rows_m1; cols_q <= cols_m1; rb_q <= base;
          row_q <= '0; col_q <= '0; acc <= '0; st <= E_ISSUE;
        end
        E_ISSUE: begin
          pend  <= 1'b1;
          opi_q <= col_q;
          if (col_q == cols_q) st <= E_DRAIN;
          else col_q <= col_q + COL_W'(1);
        end
        E_DRAIN: st <= E_HOLD;
        E_HOLD: if (res_ready) begin
          acc <= '0;
          if (last_grp) begin
            fin <= 1'b1; st <= E_IDLE;
          end else begin
            row_q <= row_q + (ROW_W+1)'(LANES);
            rb_q  <= rb_q + WA_W'(LANES) * ncols;
            col_q <= '0;
            st    <= E_ISSUE;
          end
        end
        default: st <= E_IDLE;
      endcase
      // Weight data returns one cycle after its address, aligned with opi_q.
      if (pend)
        for (int k = 0; k < LANES; k++)
          acc[k] <= acc[k] + {{(ACC_W-2*DAT_W){prod[k][2*DAT_W-1]}}, prod[k]};
    end
  end

  p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_acc) && $stable(res_row));
  p_lane0_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_mask[0]);
endmodule

// File: rtl/mlp_eval.sv
module mlp_eval
  import mlpe_pkg::*;
#(
  parameter int NI_MAX = 64,
  parameter int NH_MAX = 128,
  parameter int NO_MAX = 64,
  parameter int NCFG   = 4,
  parameter int LANES  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [$clog2(NCFG)-1:0]       cfg_idx,
  input  logic [$clog2(NI_MAX)-1:0]     cfg_ni_m1,
  input  logic [$clog2(NH_MAX)-1:0]     cfg_nh_m1,
  input  logic [$clog2(NO_MAX)-1:0]     cfg_no_m1,
  input  logic [19:0]                   cfg_base1,
  input  logic [19:0]                   cfg_base2,
  input  logic                          start,
  input  logic [$clog2(NCFG)-1:0]       start_cfg,
  output logic                          start_ready,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic signed [7:0]             in_data,
  output logic [LANES*20-1:0]           w1_addr,
  input  logic [LANES*8-1:0]            w1_data,
  output logic [LANES*20-1:0]           w2_addr,
  input  logic [LANES*8-1:0]            w2_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic signed [23:0]            out_data,
  output logic                          out_last,
  output logic                          done
);
  localparam int NI_W = $clog2(NI_MAX);
  localparam int NH_W = $clog2(NH_MAX);
  localparam int NO_W = $clog2(NO_MAX);
  localparam int CI_W = $clog2(NCFG);
  localparam int LN_W = (LANES > 1) ? $clog2(LANES) : 1;

  // Topology slots
  logic [NI_W-1:0] c_ni [NCFG];
  logic [NH_W-1:0] c_nh [NCFG];
  logic [NO_W-1:0] c_no [NCFG];
  logic [WA_W-1:0] c_b1 [NCFG];
  logic [WA_W-1:0] c_b2 [NCFG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NCFG; s++) begin
        c_ni[s] <= '0; c_nh[s] <= '0; c_no[s] <= '0; c_b1[s] <= '0; c_b2[s] <= '0;
      end
    end else if (cfg_we) begin
      c_ni[cfg_idx] <= cfg_ni_m1; c_nh[cfg_idx] <= cfg_nh_m1; c_no[cfg_idx] <= cfg_no_m1;
      c_b1[cfg_idx] <= cfg_base1; c_b2[cfg_idx] <= cfg_base2;
    end
  end

  // Hidden-layer side
  typedef enum logic [1:0] {L1_IDLE, L1_LOAD, L1_WAIT, L1_RUN} l1_t;
  l1_t l1_st;
  logic [NI_W-1:0] r_ni, in_cnt;
  logic [NH_W-1:0] r_nh;
  logic [NO_W-1:0] r_no;
  logic [WA_W-1:0] r_b1, r_b2;
  logic signed [DAT_W-1:0] xbuf [NI_MAX];
  logic signed [DAT_W-1:0] hbuf [2][NH_MAX];
  logic [1:0]      hfull;
  logic            wsel, rsel;
  logic [NH_W-1:0] m_nh [2];
  logic [NO_W-1:0] m_no [2];
  logic [WA_W-1:0] m_b2 [2];

  logic                        go1, e1_valid, e1_fin;
  logic [NI_W-1:0]             e1_op;
  logic [LANES-1:0][ACC_W-1:0] e1_acc;
  logic [NH_W:0]               e1_row;
  logic [LANES-1:0]            e1_mask;

  assign start_ready = (l1_st == L1_IDLE);
  assign in_ready    = (l1_st == L1_LOAD);
  assign go1         = (l1_st == L1_WAIT) && !hfull[wsel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_st <= L1_IDLE; r_ni <= '0; r_nh <= '0; r_no <= '0;
      r_b1 <= '0; r_b2 <= '0; in_cnt <= '0;
    end else begin
      case (l1_st)
        L1_IDLE: if (start) begin
          r_ni <= c_ni[start_cfg]; r_nh <= c_nh[start_cfg]; r_no <= c_no[start_cfg];
          r_b1 <= c_b1[start_cfg]; r_b2 <= c_b2[start_cfg];
          in_cnt <= '0; l1_st <= L1_LOAD;
        end
        L1_LOAD: if (in_valid) begin
          in_cnt <= in_cnt + NI_W'(1);
          if (in_cnt == r_ni) l1_st <= L1_WAIT;
        end
        L1_WAIT: if (go1) l1_st <= L1_RUN;
        L1_RUN:  if (e1_fin) l1_st <= L1_IDLE;
        default: l1_st <= L1_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) xbuf[in_cnt] <= in_data;
    if (e1_valid)
      for (int k = 0; k < LANES; k++)
        if (e1_mask[k])
          hbuf[wsel][NH_W'(e1_row + (NH_W+1)'(k))] <= sat_clip($signed(e1_acc[k]));
  end

  mlpe_dot_engine #(.LANES(LANES), .ROW_W(NH_W), .COL_W(NI_W)) u_hid (
    .clk(clk), .rst_n(rst_n), .go(go1), .rows_m1(r_nh), .cols_m1(r_ni), .base(r_b1),
    .w_addr(w1_addr), .w_data(w1_data), .op_idx(e1_op), .op_val(xbuf[e1_op]),
    .res_valid(e1_valid), .res_ready(1'b1), .res_acc(e1_acc), .res_row(e1_row),
    .res_mask(e1_mask), .fin(e1_fin));

  // Output-layer side
  logic                        l2_run, go2, e2_valid, e2_ready, e2_fin;
  logic [NH_W-1:0]             e2_op;
  logic [LANES-1:0][ACC_W-1:0] e2_acc;
  logic [NO_W:0]               e2_row;
  logic [LANES-1:0]            e2_mask;
  logic [LN_W-1:0]             lane_q, hi_lane;
  logic                        hs, lane_end;

  assign go2 = !l2_run && hfull[rsel];

  always_comb begin
    hi_lane = '0;
    for (int k = 0; k < LANES; k++)
      if (e2_mask[k]) hi_lane = LN_W'(k);
  end

  assign out_valid = e2_valid;
  assign out_data  = $signed(e2_acc[lane_q]);
  assign hs        = out_valid && out_ready;
  assign lane_end  = (lane_q == hi_lane);
  assign e2_ready  = hs && lane_end;
  assign out_last  = e2_valid && ((NO_W+1)'(e2_row) + (NO_W+1)'(lane_q) == (NO_W+1)'(m_no[rsel]));

  mlpe_dot_engine #(.LANES(LANES), .ROW_W(NO_W), .COL_W(NH_W)) u_out (
    .clk(clk), .rst_n(rst_n), .go(go2), .rows_m1(m_no[rsel]), .cols_m1(m_nh[rsel]),
    .base(m_b2[rsel]), .w_addr(w2_addr), .w_data(w2_data), .op_idx(e2_op),
    .op_val(hbuf[rsel][e2_op]), .res_valid(e2_valid), .res_ready(e2_ready),
    .res_acc(e2_acc), .res_row(e2_row), .res_mask(e2_mask), .fin(e2_fin));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hfull <= '0; wsel <= 1'b0; rsel <= 1'b0; l2_run <= 1'b0; lane_q <= '0; done <= 1'b0;
      for (int b = 0; b < 2; b++) begin m_nh[b] <= '0; m_no[b] <= '0; m_b2[b] <= '0; end
    end else begin
      done <= hs && out_last;
      if (go1) begin m_nh[wsel] <= r_nh; m_no[wsel] <= r_no; m_b2[wsel] <= r_b2; end
      if (e1_fin) begin hfull[wsel] <= 1'b1; wsel <= ~wsel; end
      if (go2) l2_run <= 1'b1;
      if (e2_fin) begin hfull[rsel] <= 1'b0; rsel <= ~rsel; l2_run <= 1'b0; end
      if (hs) lane_q <= lane_end ? '0 : lane_q + LN_W'(1);
    end
  end

  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_st == L1_RUN) |-> !hfull[wsel]);
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(hs && out_last));
  p_in_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid && (in_cnt == r_ni) |=> !in_ready);
endmodule

// File: tb/mlp_eval_test.sv
module mlp_eval_test;
  localparam int CLK_P = 10;
  localparam int LANES = 2;
  localparam int WAW   = 20;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0, start_cfg = '0;
  logic [5:0] cfg_ni_m1 = '0, cfg_no_m1 = '0;
  logic [6:0] cfg_nh_m1 = '0;
  logic [19:0] cfg_base1 = '0, cfg_base2 = '0;
  logic start = 1'b0, start_ready, in_valid = 1'b0, in_ready;
  logic signed [7:0] in_data = '0;
  logic [LANES*20-1:0] w1_addr, w2_addr;
  logic [LANES*8-1:0]  w1_data = '0, w2_data = '0;
  logic out_valid, out_ready = 1'b0, out_last, done;
  logic signed [23:0] out_data;

  mlp_eval #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_ni_m1(cfg_ni_m1),
    .cfg_nh_m1(cfg_nh_m1), .cfg_no_m1(cfg_no_m1), .cfg_base1(cfg_base1), .cfg_base2(cfg_base2),
    .start(start), .start_cfg(start_cfg), .start_ready(start_ready), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .w1_addr(w1_addr), .w1_data(w1_data),
    .w2_addr(w2_addr), .w2_data(w2_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .done(done));

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, rdy_mode = 0, n_done = 0, n_samples = 0;
  bit mon_en = 0, finished = 0;
  int m_ni[4], m_nh[4], m_no[4], m_b1[4], m_b2[4];
  int xv[64];
  int exp_v[$];
  bit exp_l[$];

  function automatic int wfn(input int a);
    int v;
    v = (((a * 97) ^ ((a >> 4) * 29)) + 5) & 255;
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Weight memory: one cycle of read latency on each lane (R6)
  always @(posedge clk)
    for (int k = 0; k < LANES; k++) begin
      w1_data[k*8 +: 8] <= 8'(wfn(int'(w1_addr[k*WAW +: WAW])));
      w2_data[k*8 +: 8] <= 8'(wfn(int'(w2_addr[k*WAW +: WAW])));
    end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT && !finished) begin
      check(0, "watchdog R1..", cyc, 0);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready <= 1'b1;
      1: out_ready <= (cyc % 3) != 1;
      default: out_ready <= 1'b0;
    endcase
  end

  // Per-clock monitor, sampled a quarter period after the falling edge
  bit prev_hold = 0, prev_last_hs = 0;
  logic signed [23:0] prev_data;
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (mon_en) begin
      if (prev_last_hs) check(done === 1'b1, "R9 done after last", int'(done), 1);
      else              check(done === 1'b0, "R9 done idle", int'(done), 0);
      if (done) n_done++;
      if (prev_hold)
        check(out_valid === 1'b1 && out_data === prev_data, "R7 stall hold",
              int'(out_data), int'(prev_data));
      prev_last_hs = 0;
      if (out_valid && out_ready) begin
        if (exp_v.size() == 0) check(0, "R5 unexpected beat", int'(out_data), 0);
        else begin
          // R1 R2 R4 R5 R6: value depends on slot sizes, bases, clip and lane addresses
          check(int'(out_data) == exp_v[0], "R4/R5/R6 output value", int'(out_data), exp_v[0]);
          check(out_last === exp_l[0], "R5 last flag", int'(out_last), int'(exp_l[0]));
          prev_last_hs = exp_l[0];
          void'(exp_v.pop_front());
          void'(exp_l.pop_front());
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  task automatic write_cfg(input int s, input int ni, input int nh, input int no,
                           input int b1, input int b2);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(s);
    cfg_ni_m1 = 6'(ni - 1); cfg_nh_m1 = 7'(nh - 1); cfg_no_m1 = 6'(no - 1);
    cfg_base1 = 20'(b1); cfg_base2 = 20'(b2);
    @(negedge clk);
    cfg_we = 1'b0;
    m_ni[s] = ni; m_nh[s] = nh; m_no[s] = no; m_b1[s] = b1; m_b2[s] = b2;
  endtask

  task automatic push_expected(input int s);
    int h[128];
    int acc;
    for (int j = 0; j < m_nh[s]; j++) begin
      acc = 0;
      for (int i = 0; i < m_ni[s]; i++)
        acc += xv[i] * wfn((m_b1[s] + j * m_ni[s] + i) & 20'hFFFFF);
      h[j] = (acc > 127) ? 127 : (acc < -128) ? -128 : acc;
    end
    for (int k = 0; k < m_no[s]; k++) begin
      acc = 0;
      for (int j = 0; j < m_nh[s]; j++)
        acc += h[j] * wfn((m_b2[s] + k * m_nh[s] + j) & 20'hFFFFF);
      exp_v.push_back(acc);
      exp_l.push_back(k == m_no[s] - 1);
    end
  endtask

  task automatic run(input int s);
    @(negedge clk); #1;
    while (!start_ready) begin @(negedge clk); #1; end
    start = 1'b1; start_cfg = 2'(s);
    push_expected(s);   // R2: topology copied at the start edge
    n_samples++;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < m_ni[s]; i++) begin
      if (i != 0) @(negedge clk);
      in_valid = 1'b1; in_data = 8'(xv[i]);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(in_ready === 1'b0, "R3 in_ready drops after N inputs", int'(in_ready), 0);
  endtask

  task automatic drain();
    while (exp_v.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    check(start_ready === 1'b1, "R10 start_ready", int'(start_ready), 1);
    check(in_ready === 1'b0, "R10 in_ready", int'(in_ready), 0);
    check(out_valid === 1'b0, "R10 out_valid", int'(out_valid), 0);
    check(done === 1'b0, "R10 done", int'(done), 0);
    mon_en = 1;

    // R1: default slot is 1x1x1 with bases 0
    for (int s = 0; s < 4; s++) begin
      m_ni[s] = 1; m_nh[s] = 1; m_no[s] = 1; m_b1[s] = 0; m_b2[s] = 0;
    end
    xv[0] = 93;
    run(2);
    drain();

    write_cfg(0, 3, 5, 3, 100, 5000);
    write_cfg(1, 1, 1, 1, 0, 7);
    write_cfg(2, 64, 128, 64, 'hFF000, 'h40000);
    write_cfg(3, 16, 9, 7, 3, 'h800);

    // small values, odd counts (R4 R5 R6)
    for (int i = 0; i < 64; i++) xv[i] = (i % 5) - 2;
    run(0); drain();
    xv[0] = -7;
    run(1); drain();
    // large values drive the hidden clip (R4)
    xv[0] = 127; xv[1] = -128; xv[2] = 100;
    run(0); drain();

    // R8: output held back, layers decoupled
    rdy_mode = 2;
    for (int i = 0; i < 64; i++) xv[i] = (i * 3) % 7 - 3;
    run(3);
    for (int i = 0; i < 64; i++) xv[i] = (i * 5) % 11 - 5;
    run(3);
    repeat (300) @(negedge clk);
    #1;
    check(start_ready === 1'b1, "R8 hidden engine free while output stalled", int'(start_ready), 1);
    for (int i = 0; i < 64; i++) xv[i] = 60 - i * 9;
    run(3);
    // R2: rewriting the slot after its start must not disturb that run
    write_cfg(3, 5, 4, 2, 77, 900);
    repeat (400) @(negedge clk);
    #1;
    check(start_ready === 1'b0, "R8 stall with both banks full", int'(start_ready), 0);
    check(out_valid === 1'b1, "R7 output waiting under back-pressure", int'(out_valid), 1);
    rdy_mode = 1;
    drain();
    run(3); drain();

    // full-size topology with weight address wrap
    rdy_mode = 1;
    for (int i = 0; i < 64; i++) xv[i] = ((i * 7) % 9) - 4;
    run(2); drain();
    rdy_mode = 0;

    check(exp_v.size() == 0, "R5 all outputs delivered", exp_v.size(), 0);
    check(n_done == n_samples, "R9 one done per sample", n_done, n_samples);
    finished = 1;
    summary();
    $finish;
  end
endmodule